// File: doc/BRIEF.md
# Integer Status Flag Generator

This block sits beside the integer ALU and turns each completed operation into updates of the fixed-point status bits. It receives the operands, the result and the enables that the decoder supplies for the instruction. It derives two carry bits: a full-width carry and a low-half carry. It also derives the matching pair of overflow bits and a sticky summary-overflow bit. When the instruction asks for a recorded result, it also forms the 4-bit condition field 0. It does not perform the arithmetic itself.

Carry is not taken from the adder. It is inferred after the fact: a carry is reported when any contributing operand, compared unsigned, is larger than the result. Overflow follows the usual signed rule on the first two operands. A divide unit can force overflow on. All updates are gated per instruction and commit on one clock edge, qualified by a valid strobe.

Top module: `int_flag_gen`

## Requirements
- R1: While `rst_n` is low, and after its release, `ca_o`, `ca32_o`, `ov_o`, `ov32_o`, `so_o` and `cr0_o` all read 0.
- R2: In a cycle where `valid_i` is low, none of the outputs change at the next edge.
- R3: Operand handling works as follows.
  - When `inv_a_i` is 1, the first operand is bitwise inverted before any carry or overflow evaluation.
  - When `imm_valid_i` is 1, `imm_i` joins the operand list after the first operand and after the second operand when present.
- R4: When carry is updated, `ca_o` becomes 1 exactly when some operand in the list, compared unsigned over all DATA_W bits, exceeds `result_i`.
- R5: When carry is updated, `ca32_o` becomes 1 exactly when some operand's low LOW_W bits, compared unsigned, exceed the low LOW_W bits of `result_i`.
- R6: Carry gating works as follows.
  - Neither carry bit changes unless `carry_en_i` is 1.
  - `ca_o` also stays as it is when `ca_done_i` is 1.
  - `ca32_o` also stays as it is when `ca32_done_i` is 1.
- R7: With `ov_en_i` set and no divide overflow, `ov_o` and `ov32_o` follow the signed overflow rule on the first two operands.
  - The first two operands are the first operand and the second operand, or the immediate when no second operand is present.
  - `ov_o` is 1 when those two operands share the same bit DATA_W-1 and the result's bit DATA_W-1 differs from it.
  - `ov32_o` applies the same rule to bit LOW_W-1.
- R8: Divide overflow and the operand count work as follows.
  - With `ov_en_i` and `div_ovf_i` both 1, `ov_o` and `ov32_o` become 1.
  - Without `div_ovf_i`, overflow is evaluated only if at least two operands are present.
  - If it is not evaluated, `ov_o`, `ov32_o` and `so_o` keep their values.
- R9: Whenever overflow is evaluated, `so_o` becomes its old value OR the new `ov_o`; it never falls except on reset.
- R10: When `rc_en_i` is 1, `cr0_o` becomes {negative, positive, zero, SO}, listed from bit 3 down to bit 0.
  - The first three bits are the signed comparison of `result_i` against zero.
  - SO is the value `so_o` takes at the same edge.
  - When `rc_en_i` is 0, `cr0_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | An operation completes this cycle |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| opb_present_i | input | 1 | Second operand takes part |
| imm_i | input | DATA_W | Immediate operand |
| imm_valid_i | input | 1 | Immediate takes part |
| inv_a_i | input | 1 | Invert first operand before evaluation |
| result_i | input | DATA_W | Operation result |
| carry_en_i | input | 1 | Instruction outputs carry |
| ca_done_i | input | 1 | Instruction writes the full carry itself |
| ca32_done_i | input | 1 | Instruction writes the low carry itself |
| ov_en_i | input | 1 | Overflow enabled |
| div_ovf_i | input | 1 | Divide overflow indication |
| rc_en_i | input | 1 | Record bit: update condition field 0 |
| ca_o | output | 1 | Full-width carry |
| ca32_o | output | 1 | Low-half carry |
| ov_o | output | 1 | Full-width overflow |
| ov32_o | output | 1 | Low-half overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Condition field 0 {neg,pos,zero,so} |

## Verification
The bench builds the block with its defaults: DATA_W = 64 and LOW_W = 32. With these values the low-half carry and overflow sit on a different bit than the full-width ones, so an operand can produce a low carry without a full carry. The random vectors mix results taken from true sums with free random results. Forced sign-bit patterns make both overflow forms and the sticky bit reachable. The directed cases cover the inversion and immediate paths, the per-flag write suppression, and the single-operand and divide cases of overflow.

// File: rtl/int_flag_pkg.sv
// Shared types for the integer status flag generator.
// Assumes: flags are single bits; condition field 0 is 4 bits wide.
package int_flag_pkg;

    typedef struct packed {
        logic ca;
        logic ca32;
        logic ov;
        logic ov32;
        logic so;
    } stat_flags_t;

    // Bit positions inside condition field 0; its consumer decodes them.
    localparam int CR0_NEG  = 3;
    localparam int CR0_POS  = 2;
    localparam int CR0_ZERO = 1;
    localparam int CR0_SO   = 0;

endpackage

// File: rtl/ifg_carry_detect.sv
// Infers carry by comparing each valid operand with the result, unsigned,
// at full width and over the low half.
// Assumes: operand 0 has already been conditioned (inverted if needed).
module ifg_carry_detect #(
    parameter int DATA_W = 64,
    parameter int LOW_W  = 32,
    parameter int N_OPS  = 3
) (
    input  logic [N_OPS-1:0][DATA_W-1:0] ops_i,
    input  logic [N_OPS-1:0]             op_vld_i,
    input  logic [DATA_W-1:0]            result_i,
    output logic                         carry_full_o,
    output logic                         carry_low_o
);
    logic [N_OPS-1:0] gt_full;
    logic [N_OPS-1:0] gt_low;

    // One pair of unsigned comparators per operand slot.
    for (genvar i = 0; i < N_OPS; i++) begin : g_cmp
        assign gt_full[i] = op_vld_i[i] && (ops_i[i] > result_i);
        assign gt_low[i]  = op_vld_i[i] &&
                            (ops_i[i][LOW_W-1:0] > result_i[LOW_W-1:0]);
    end

    assign carry_full_o = |gt_full;
    assign carry_low_o  = |gt_low;
endmodule

// File: rtl/ifg_ovf_detect.sv
// Signed overflow rule, evaluated at each tracked width from sign bits
// only: the operands agree in sign and the result disagrees.
// Assumes: index 1 is the full width, index 0 the low half.
module ifg_ovf_detect #(
    parameter int N_W = 2
) (
    input  logic [N_W-1:0] sgn_a_i,
    input  logic [N_W-1:0] sgn_b_i,
    input  logic [N_W-1:0] sgn_r_i,
    output logic [N_W-1:0] ovf_o
);
    // One overflow rule per width.
    for (genvar w = 0; w < N_W; w++) begin : g_w
        assign ovf_o[w] = (sgn_a_i[w] == sgn_b_i[w]) && (sgn_r_i[w] != sgn_a_i[w]);
    end
endmodule

// File: rtl/ifg_cr0_form.sv
// Forms condition field 0 from the signed result and the summary bit.
// Assumes: so_i is the value the summary bit takes at the same edge.
module ifg_cr0_form
    import int_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              so_i,
    output logic [3:0]        cr0_o
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (result_i == '0);
    assign is_neg  = result_i[DATA_W-1];

    // Assemble the field at its fixed bit positions.
    always_comb begin
        cr0_o           = '0;
        cr0_o[CR0_NEG]  = is_neg;
        cr0_o[CR0_POS]  = !is_neg && !is_zero;
        cr0_o[CR0_ZERO] = is_zero;
        cr0_o[CR0_SO]   = so_i;
    end
endmodule

// File: rtl/int_flag_gen.sv
// Integer status flag generator: computes the next values of the carry,
// overflow and summary bits and of condition field 0, and commits them on
// a valid strobe.
// Assumes: the inputs are stable for the cycle in which valid_i is high.
module int_flag_gen
    import int_flag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              opb_present_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              imm_valid_i,
    input  logic              inv_a_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_en_i,
    input  logic              ca_done_i,
    input  logic              ca32_done_i,
    input  logic              ov_en_i,
    input  logic              div_ovf_i,
    input  logic              rc_en_i,
    output logic              ca_o,
    output logic              ca32_o,
    output logic              ov_o,
    output logic              ov32_o,
    output logic              so_o,
    output logic [3:0]        cr0_o
);
    localparam int N_OPS = 3;
    localparam int SGN_F = DATA_W - 1;
    localparam int SGN_L = LOW_W - 1;

    stat_flags_t cur_q, nxt;
    logic [3:0]  cr0_q, cr0_nxt, cr0_cand;

    logic [DATA_W-1:0]            op_a;
    logic [DATA_W-1:0]            op_second;
    logic [N_OPS-1:0][DATA_W-1:0] ops;
    logic [N_OPS-1:0]             op_vld;
    logic                         two_ops;
    logic                         c_full, c_low;
    logic [1:0]                   ovf;
    logic                         ov_go;

    // Condition the first operand and pick the second for overflow.
    always_comb begin
        op_a      = inv_a_i ? ~opa_i : opa_i;
        op_second = opb_present_i ? opb_i : imm_i;
        two_ops   = opb_present_i || imm_valid_i;
        ops       = {imm_i, opb_i, op_a};
        op_vld    = {imm_valid_i, opb_present_i, 1'b1};
    end

    ifg_carry_detect #(
        .DATA_W (DATA_W),
        .LOW_W  (LOW_W),
        .N_OPS  (N_OPS)
    ) u_carry (
        .ops_i        (ops),
        .op_vld_i     (op_vld),
        .result_i     (result_i),
        .carry_full_o (c_full),
        .carry_low_o  (c_low)
    );

    ifg_ovf_detect #(
        .N_W (2)
    ) u_ovf (
        .sgn_a_i ({op_a[SGN_F], op_a[SGN_L]}),
        .sgn_b_i ({op_second[SGN_F], op_second[SGN_L]}),
        .sgn_r_i ({result_i[SGN_F], result_i[SGN_L]}),
        .ovf_o   (ovf)
    );

    // Next flag values under the per-instruction gates.
    always_comb begin
        nxt   = cur_q;
        ov_go = ov_en_i && (div_ovf_i || two_ops);
        if (carry_en_i) begin
            if (!ca_done_i)   nxt.ca   = c_full;
            if (!ca32_done_i) nxt.ca32 = c_low;
        end
        if (ov_go) begin
            nxt.ov   = div_ovf_i ? 1'b1 : ovf[1];
            nxt.ov32 = div_ovf_i ? 1'b1 : ovf[0];
            nxt.so   = cur_q.so | nxt.ov;
        end
    end

    ifg_cr0_form #(
        .DATA_W (DATA_W)
    ) u_cr0 (
        .result_i (result_i),
        .so_i     (nxt.so),
        .cr0_o    (cr0_cand)
    );

    // Condition field 0 changes only on a recorded operation.
    assign cr0_nxt = rc_en_i ? cr0_cand : cr0_q;

    // Status register: clear on reset, commit on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            cr0_q <= '0;
        end else if (valid_i) begin
            cur_q <= nxt;
            cr0_q <= cr0_nxt;
        end
    end

    assign ca_o   = cur_q.ca;
    assign ca32_o = cur_q.ca32;
    assign ov_o   = cur_q.ov;
    assign ov32_o = cur_q.ov32;
    assign so_o   = cur_q.so;
    assign cr0_o  = cr0_q;
endmodule

// File: rtl/int_flag_gen_chk.sv
// Property checker for the integer status flag generator, bound to the top.
module int_flag_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic       carry_en_i,
    input logic       ca_done_i,
    input logic       ca32_done_i,
    input logic       ov_en_i,
    input logic       div_ovf_i,
    input logic       rc_en_i,
    input logic       ca_o,
    input logic       ca32_o,
    input logic       ov_o,
    input logic       ov32_o,
    input logic       so_o,
    input logic [3:0] cr0_o
);
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o})); // R2

    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !carry_en_i |=> $stable(ca_o) && $stable(ca32_o)); // R6

    AST_CA_SELF_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ca_done_i |=> $stable(ca_o)); // R6

    AST_CA32_SELF_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ca32_done_i |=> $stable(ca32_o)); // R6

    AST_DIV_FORCES_OV: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ov_en_i && div_ovf_i |=> ov_o && ov32_o); // R8

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        so_o |=> so_o); // R9

    AST_SO_COVERS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ov_en_i |=> (so_o || !ov_o)); // R9

    AST_CR0_SO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && rc_en_i |=> cr0_o[0] == so_o); // R10

    AST_CR0_ONE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && rc_en_i |=> $countones(cr0_o[3:1]) == 1); // R10
endmodule

bind int_flag_gen int_flag_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .carry_en_i  (carry_en_i),
    .ca_done_i   (ca_done_i),
    .ca32_done_i (ca32_done_i),
    .ov_en_i     (ov_en_i),
    .div_ovf_i   (div_ovf_i),
    .rc_en_i     (rc_en_i),
    .ca_o        (ca_o),
    .ca32_o      (ca32_o),
    .ov_o        (ov_o),
    .ov32_o      (ov32_o),
    .so_o        (so_o),
    .cr0_o       (cr0_o)
);

// File: tb/int_flag_gen_tb.sv
// Bench: directed corner cases plus seeded random vectors, compared with
// a reference model written from the requirements.
module int_flag_gen_tb;
    localparam int DW = 64;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [DW-1:0] opa_i = '0, opb_i = '0, imm_i = '0, result_i = '0;
    logic          opb_present_i = 1'b0, imm_valid_i = 1'b0, inv_a_i = 1'b0;
    logic          carry_en_i = 1'b0, ca_done_i = 1'b0, ca32_done_i = 1'b0;
    logic          ov_en_i = 1'b0, div_ovf_i = 1'b0, rc_en_i = 1'b0;
    logic          ca_o, ca32_o, ov_o, ov32_o, so_o;
    logic [3:0]    cr0_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state.
    logic m_ca = 0, m_ca32 = 0, m_ov = 0, m_ov32 = 0, m_so = 0;
    logic [3:0] m_cr0 = '0;

    always #5 clk = ~clk;

    int_flag_gen #(.DATA_W(DW), .LOW_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .opa_i(opa_i), .opb_i(opb_i), .opb_present_i(opb_present_i),
        .imm_i(imm_i), .imm_valid_i(imm_valid_i), .inv_a_i(inv_a_i),
        .result_i(result_i), .carry_en_i(carry_en_i), .ca_done_i(ca_done_i),
        .ca32_done_i(ca32_done_i), .ov_en_i(ov_en_i), .div_ovf_i(div_ovf_i),
        .rc_en_i(rc_en_i), .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o),
        .ov32_o(ov32_o), .so_o(so_o), .cr0_o(cr0_o)
    );

    function automatic logic [DW-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance the model by one edge from the current inputs.
    task automatic model_step();
        logic [DW-1:0] a, second;
        logic c64, c32, ov64, ovl, sgn, go;
        if (!valid_i) return;
        a = inv_a_i ? ~opa_i : opa_i;                       // R3
        c64 = (a > result_i) ||
              (opb_present_i && opb_i > result_i) ||
              (imm_valid_i && imm_i > result_i);            // R4
        c32 = (a[LW-1:0] > result_i[LW-1:0]) ||
              (opb_present_i && opb_i[LW-1:0] > result_i[LW-1:0]) ||
              (imm_valid_i && imm_i[LW-1:0] > result_i[LW-1:0]); // R5
        if (carry_en_i) begin                               // R6
            if (!ca_done_i)   m_ca   = c64;
            if (!ca32_done_i) m_ca32 = c32;
        end
        second = opb_present_i ? opb_i : imm_i;
        sgn  = a[DW-1];
        ov64 = (sgn == second[DW-1]) && (result_i[DW-1] != sgn);  // R7
        ovl  = (a[LW-1] == second[LW-1]) && (result_i[LW-1] != a[LW-1]);
        go = ov_en_i && (div_ovf_i || opb_present_i || imm_valid_i); // R8
        if (go) begin
            m_ov   = div_ovf_i ? 1'b1 : ov64;
            m_ov32 = div_ovf_i ? 1'b1 : ovl;
            m_so   = m_so | m_ov;                           // R9
        end
        if (rc_en_i)                                        // R10
            m_cr0 = {result_i[DW-1], !result_i[DW-1] && result_i != '0,
                     result_i == '0, m_so};
    endtask

    // Drive is already set at a falling edge; step one cycle and compare.
    task automatic apply(string tag);
        model_step();
        @(negedge clk);
        chk({tag, " R4 ca"},     {3'b0, ca_o},   {3'b0, m_ca});
        chk({tag, " R5 ca32"},   {3'b0, ca32_o}, {3'b0, m_ca32});
        chk({tag, " R7 ov"},     {3'b0, ov_o},   {3'b0, m_ov});
        chk({tag, " R7 ov32"},   {3'b0, ov32_o}, {3'b0, m_ov32});
        chk({tag, " R9 so"},     {3'b0, so_o},   {3'b0, m_so});
        chk({tag, " R10 cr0"},   cr0_o,          m_cr0);
    endtask

    task automatic clear_ctl();
        opb_present_i = 0; imm_valid_i = 0; inv_a_i = 0; carry_en_i = 0;
        ca_done_i = 0; ca32_done_i = 0; ov_en_i = 0; div_ovf_i = 0; rc_en_i = 0;
        valid_i = 1;
    endtask

    initial begin : watchdog
        #(150000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk); @(negedge clk);
        chk("R1 reset", {ca_o, ca32_o, ov_o, ov32_o}, 4'h0);
        chk("R1 reset", {3'b0, so_o}, 4'h0);
        chk("R1 reset", cr0_o, 4'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", cr0_o, 4'h0);

        // R3: inversion makes small opa large -> carry on both widths.
        clear_ctl(); carry_en_i = 1; inv_a_i = 1; opa_i = 64'h0;
        result_i = 64'h5; rc_en_i = 1;
        apply("R3 invert");
        chk("R3 invert ca", {3'b0, ca_o}, 4'h1);

        // R3: immediate alone causes the carry.
        clear_ctl(); carry_en_i = 1; opa_i = 64'h1; imm_valid_i = 1;
        imm_i = 64'hFFFF_0000_0000_0000; result_i = 64'h10;
        apply("R3 imm");
        chk("R3 imm ca", {2'b0, ca_o, ca32_o}, 4'h2);

        // R5: low-half carry without full carry.
        clear_ctl(); carry_en_i = 1; opa_i = 64'h0000_0000_FFFF_FFFF;
        result_i = 64'h0000_0001_0000_0000;
        apply("R5 low only");

        // R6: self-written flags stay put; carry off holds both.
        clear_ctl(); carry_en_i = 1; ca_done_i = 1; ca32_done_i = 1;
        opa_i = 64'h0; result_i = 64'h0;
        apply("R6 done");
        chk("R6 done ca", {2'b0, ca_o, ca32_o}, 4'h1);
        clear_ctl(); opa_i = 64'h0; result_i = 64'h0;
        apply("R6 disabled");

        // R8: single operand, no divide -> overflow untouched.
        clear_ctl(); ov_en_i = 1; opa_i = 64'h7FFF_FFFF_FFFF_FFFF;
        result_i = 64'h8000_0000_0000_0000;
        apply("R8 single op");
        // R8/R9: divide forces overflow and sets summary.
        clear_ctl(); ov_en_i = 1; div_ovf_i = 1; rc_en_i = 1; result_i = 64'h0;
        apply("R8 div");
        chk("R9 so set", {3'b0, so_o}, 4'h1);
        // R9: later no-overflow op clears OV but keeps SO.
        clear_ctl(); ov_en_i = 1; opb_present_i = 1; opa_i = 1; opb_i = 1;
        result_i = 2; rc_en_i = 1;
        apply("R9 sticky");
        chk("R10 cr0 pos", cr0_o, 4'b0101);

        // R2: no valid -> nothing changes despite active enables.
        clear_ctl(); valid_i = 0; carry_en_i = 1; ov_en_i = 1; rc_en_i = 1;
        opa_i = '1; result_i = '0; opb_present_i = 1;
        apply("R2 idle");
        chk("R2 idle cr0", cr0_o, 4'b0101);

        // Reset again before the random phase.
        rst_n = 0; valid_i = 0; @(negedge clk);
        m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr0 = '0;
        rst_n = 1;

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            valid_i = r[0] | r[1];
            opb_present_i = r[2]; imm_valid_i = r[3]; inv_a_i = r[4];
            carry_en_i = r[5]; ca_done_i = r[6] & r[7]; ca32_done_i = r[8] & r[9];
            ov_en_i = r[10]; div_ovf_i = r[11] & r[12] & r[13]; rc_en_i = r[14];
            opa_i = rnd64(); opb_i = rnd64(); imm_i = rnd64();
            if (r[15]) begin opa_i[DW-1] = r[16]; opb_i[DW-1] = r[16]; end
            if (r[17]) begin opa_i[LW-1] = r[18]; opb_i[LW-1] = r[18]; end
            case (r[21:19])
                3'd0: result_i = '0;
                3'd1: result_i = opa_i + opb_i;
                3'd2: result_i = opb_i + imm_i;
                3'd3: result_i = rnd64() >> r[27:22];
                default: result_i = rnd64();
            endcase
            apply("rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule